// File: doc/BRIEF.md
# Shared Work RAM Ownership Register

This block is a small control register. It decides which of two processors may use a shared work RAM. It also picks which 128 KB bank of program RAM shows through the main processor's window, and it holds eight write-protect bits. The main processor writes the register and reads it back. The sub side has three dedicated inputs: one hands the RAM back to the main side, one loads the mode bit, and one says it is stalled waiting for the RAM.

Ownership uses a two-bit handshake: a "give to sub" flag (DMNA) and a "returned" flag (RET). The meaning of a main-side write to DMNA depends on the mode bit:
- In single-owner mode, a 1 hands the whole RAM to the sub side.
- In split mode, a 1 only raises a request to go back to single-owner mode.
- In split mode, a 0 stores DMNA as 1.

Every ownership change lands on a single clock edge. In single-owner mode exactly one side is mapped at any time.

Top module: `wram_owner_reg`

## Requirements
- R1: After reset the readback is 0x0001 (RET=1, all else 0). In the same state `main_map_en`=1, `sub_map_en`=0, `sub_wake`=0, `split_ret_req`=0 and `bank_base`=0.
- R2: Every main write loads the bank number from `wr_data[7:6]`, in either mode. From the next cycle, readback bits [7:6] show that number and `bank_base` equals the number times 131072.
- R3: A word write (`wr_word`=1) loads the write-protect bits from `wr_data[15:8]` into readback bits [15:8]. A byte write (`wr_word`=0) leaves them unchanged.
- R4: The readback layout is [15:8] write-protect, [7:6] bank, [5:3] always 0, [2] mode, [1] DMNA, [0] RET. A main write never changes mode or RET directly through bits [2] and [0], and bits [5:3] read 0 even after 1s are written there.
- R5: In single-owner mode (mode=0), a main write with bit 1 set clears RET and sets DMNA. From the next cycle `main_map_en`=0 and `sub_map_en`=1.
- R6: In single-owner mode, a main write with bit 1 clear leaves DMNA, RET and both map enables unchanged.
- R7: In split mode (mode=1), a main write with bit 1 set raises `split_ret_req` and leaves DMNA unchanged.
- R8: In split mode, a main write with bit 1 clear stores DMNA as 1.
- R9: `sub_ret` sets RET and clears both DMNA and `split_ret_req` on the next edge. It takes priority over an ownership change requested by a main write in the same cycle. The bank and write-protect fields of that write still apply.
- R10: `sub_wake` is high for exactly the one cycle after a single-owner hand-over edge, and only if `sub_stalled` was high at that edge. At all other times it is 0.
- R11: `sub_mode_we` loads readback bit [2] from `sub_mode_val` on the next edge. While mode=1, both map enables are 0.
- R12: `main_map_en` and `sub_map_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Main-side write strobe |
| wr_word | input | 1 | 1 = word write, 0 = low-byte write |
| wr_data | input | 16 | Main-side write data |
| sub_ret | input | 1 | Sub side returns the RAM to the main side |
| sub_mode_we | input | 1 | Sub side loads the mode bit |
| sub_mode_val | input | 1 | Mode value (0 single-owner, 1 split) |
| sub_stalled | input | 1 | Sub processor is stalled waiting for the RAM |
| rd_data | output | 16 | Masked main-side readback |
| main_map_en | output | 1 | Main window maps the whole RAM |
| sub_map_en | output | 1 | Sub side may access the whole RAM |
| sub_wake | output | 1 | One-cycle release of a stalled sub processor |
| split_ret_req | output | 1 | Pending request to return to single-owner mode |
| bank_base | output | 19 | Byte offset of the selected program RAM bank |

## Verification
All results come from one register stage, so every output reflects a stimulus one clock edge after the edge that takes it. This holds for the readback, the map enables, `bank_base`, `split_ret_req` and the one-cycle `sub_wake` pulse. The driver applies inputs at the falling edge and queues the expected outputs computed from a bench-side model. The monitor pops the queue 5 ns after the next rising edge, which is the first point where those outputs are valid. The reset state is checked while reset is held, before any item is queued.

// File: rtl/wram_owner_pkg.sv
package wram_owner_pkg;
    localparam int WP_W        = 8;
    localparam int BANK_W      = 2;
    localparam int BANK_BYTES2 = 17;
    localparam int BASE_W      = BANK_W + BANK_BYTES2;

    typedef struct packed {
        logic [WP_W-1:0]   wp;
        logic [BANK_W-1:0] bank;
        logic              mode;
        logic              dmna;
        logic              ret;
        logic              req;
        logic              wake;
    } wram_state_t;
endpackage

// File: rtl/wram_view.sv
module wram_view
    import wram_owner_pkg::*;
(
    input  wram_state_t       st,
    output logic [15:0]       rd_data,
    output logic              main_map_en,
    output logic              sub_map_en,
    output logic [BASE_W-1:0] bank_base
);
    localparam int PAD_W = 8 - BANK_W - 3;

    always_comb begin
        rd_data     = {st.wp, st.bank, {PAD_W{1'b0}}, st.mode, st.dmna, st.ret};
        main_map_en = !st.mode && st.ret;
        sub_map_en  = !st.mode && !st.ret;
        bank_base   = {st.bank, {BANK_BYTES2{1'b0}}};
    end
endmodule

// File: rtl/wram_owner_reg.sv
module wram_owner_reg
    import wram_owner_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [15:0]       wr_data,
    input  logic              sub_ret,
    input  logic              sub_mode_we,
    input  logic              sub_mode_val,
    input  logic              sub_stalled,
    output logic [15:0]       rd_data,
    output logic              main_map_en,
    output logic              sub_map_en,
    output logic              sub_wake,
    output logic              split_ret_req,
    output logic [BASE_W-1:0] bank_base
);
    localparam int DMNA_BIT = 1;
    localparam int BANK_LO  = 6;

    wram_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (wr_en) begin
            st_d.bank = wr_data[BANK_LO +: BANK_W];
            if (wr_word) st_d.wp = wr_data[15:8];
            if (!st_q.mode) begin
                if (wr_data[DMNA_BIT]) begin
                    st_d.dmna = 1'b1;
                    st_d.ret  = 1'b0;
                    st_d.wake = sub_stalled;
                end
            end else begin
                if (wr_data[DMNA_BIT]) st_d.req  = 1'b1;
                else                   st_d.dmna = 1'b1;
            end
        end
        if (sub_mode_we) st_d.mode = sub_mode_val;
        if (sub_ret) begin
            st_d.ret  = 1'b1;
            st_d.dmna = 1'b0;
            st_d.req  = 1'b0;
            st_d.wake = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ret <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    wram_view u_view (
        .st          (st_q),
        .rd_data     (rd_data),
        .main_map_en (main_map_en),
        .sub_map_en  (sub_map_en),
        .bank_base   (bank_base)
    );

    assign sub_wake      = st_q.wake;
    assign split_ret_req = st_q.req;

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[7:6] == $past(wr_data[7:6]));

    // R3
    wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_word) |=> $stable(rd_data[15:8]));

    // R5
    single_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_data[2] && wr_data[1] && !sub_ret && !sub_mode_we)
        |=> (sub_map_en && !main_map_en && rd_data[1] && !rd_data[0]));

    // R8
    split_dmna_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[2] && !wr_data[1] && !sub_ret) |=> rd_data[1]);

    // R9
    sub_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_ret |=> (rd_data[0] && !rd_data[1] && !split_ret_req));

    // R10
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_wake |-> ($past(sub_stalled) && $past(wr_en) && !$past(sub_ret)));
endmodule

// File: tb/wram_owner_reg_test.sv
module wram_owner_reg_test;
    localparam int BASE_W = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, wr_word = 1'b0;
    logic [15:0]       wr_data = '0;
    logic              sub_ret = 1'b0, sub_mode_we = 1'b0, sub_mode_val = 1'b0, sub_stalled = 1'b0;
    logic [15:0]       rd_data;
    logic              main_map_en, sub_map_en, sub_wake, split_ret_req;
    logic [BASE_W-1:0] bank_base;

    always #10 clk = ~clk;

    wram_owner_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
        .sub_ret(sub_ret), .sub_mode_we(sub_mode_we), .sub_mode_val(sub_mode_val),
        .sub_stalled(sub_stalled), .rd_data(rd_data), .main_map_en(main_map_en),
        .sub_map_en(sub_map_en), .sub_wake(sub_wake), .split_ret_req(split_ret_req),
        .bank_base(bank_base)
    );

    typedef struct {
        logic [15:0]       rd;
        logic              mm, sm, wk, rq;
        logic [BASE_W-1:0] base;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic [7:0] m_wp;
    logic [1:0] m_bank;
    logic       m_mode, m_dmna, m_ret, m_req, m_wake;

    task automatic push_model(input string tag);
        exp_t e;
        e.rd   = {m_wp, m_bank, 3'b000, m_mode, m_dmna, m_ret};
        e.mm   = !m_mode && m_ret;
        e.sm   = !m_mode && !m_ret;
        e.wk   = m_wake;
        e.rq   = m_req;
        e.base = BASE_W'(m_bank) << 17;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(input logic we, input logic word, input logic [15:0] dat,
                        input logic sret, input logic mwe, input logic mval,
                        input logic stall, input string tag);
        logic       n_mode, n_dmna, n_ret, n_req, n_wake;
        logic [7:0] n_wp;
        logic [1:0] n_bank;
        @(negedge clk);
        wr_en = we; wr_word = word; wr_data = dat; sub_ret = sret;
        sub_mode_we = mwe; sub_mode_val = mval; sub_stalled = stall;
        n_wp = m_wp; n_bank = m_bank; n_mode = m_mode; n_dmna = m_dmna;
        n_ret = m_ret; n_req = m_req; n_wake = 1'b0;
        if (we) begin
            n_bank = dat[7:6];
            if (word) n_wp = dat[15:8];
            if (!m_mode && dat[1]) begin n_dmna = 1; n_ret = 0; n_wake = stall; end
            if (m_mode && dat[1])  n_req = 1;
            if (m_mode && !dat[1]) n_dmna = 1;
        end
        if (mwe) n_mode = mval;
        if (sret) begin n_ret = 1; n_dmna = 0; n_req = 0; n_wake = 0; end
        m_wp = n_wp; m_bank = n_bank; m_mode = n_mode; m_dmna = n_dmna;
        m_ret = n_ret; m_req = n_req; m_wake = n_wake;
        push_model(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 16'h0000, 0, 0, 0, 0, tag);
    endtask

    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (rd_data !== e.rd || main_map_en !== e.mm || sub_map_en !== e.sm ||
                sub_wake !== e.wk || split_ret_req !== e.rq || bank_base !== e.base) begin
                n_fail++;
                $display("FAIL %s: got rd=%h mm=%b sm=%b wk=%b rq=%b base=%h exp rd=%h mm=%b sm=%b wk=%b rq=%b base=%h",
                         e.tag, rd_data, main_map_en, sub_map_en, sub_wake, split_ret_req, bank_base,
                         e.rd, e.mm, e.sm, e.wk, e.rq, e.base);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        m_wp = 0; m_bank = 0; m_mode = 0; m_dmna = 0; m_ret = 1; m_req = 0; m_wake = 0;
        repeat (3) @(negedge clk);
        n_vec++;
        // R1: reset state checked while reset is held
        if (rd_data !== 16'h0001 || main_map_en !== 1 || sub_map_en !== 0 || sub_wake !== 0 ||
            split_ret_req !== 0 || bank_base !== '0) begin
            n_fail++;
            $display("FAIL R1: got rd=%h mm=%b sm=%b exp rd=0001 mm=1 sm=0", rd_data, main_map_en, sub_map_en);
        end
        rst_n = 1'b1;
        idle("R1 idle after reset");
        // R4 R5 R2: byte write 0xFF in single mode, bits 5:3, 2, 0 ignored
        step(1, 0, 16'h00FF, 0, 0, 0, 0, "R5 R4 R2 hand-over byte write");
        idle("R10 no wake without stall");
        step(0, 0, 16'h0000, 1, 0, 0, 0, "R9 sub return");
        // R6 R3: word write with DMNA=0
        step(1, 1, 16'hA540, 0, 0, 0, 1, "R6 R3 single mode DMNA=0");
        // R10: hand-over while sub stalled
        step(1, 1, 16'h3C02, 0, 0, 0, 1, "R10 R5 hand-over with stall");
        idle("R10 wake lasts one cycle");
        step(1, 0, 16'hFF80, 0, 0, 0, 0, "R3 byte write keeps protect bits");
        // R9: sub return wins over simultaneous hand-over
        step(1, 1, 16'h5A42, 1, 0, 0, 1, "R9 priority over main write");
        step(0, 0, 16'h0000, 0, 1, 1, 0, "R11 enter split mode");
        step(1, 1, 16'h11C2, 0, 0, 0, 0, "R7 split DMNA=1 request");
        step(1, 0, 16'h0000, 0, 0, 0, 0, "R8 split DMNA=0 stores 1");
        idle("R12 split mode maps off");
        step(0, 0, 16'h0000, 1, 0, 0, 0, "R9 return clears request");
        step(0, 0, 16'h0000, 0, 1, 0, 0, "R11 back to single mode");
        step(1, 1, 16'h0042, 0, 0, 0, 0, "R12 R2 hand-over bank 1");
        idle("R12 exclusive maps");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule